// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps a separate interrupt-enable word and a separate interrupt-status word for each of five localities, and it drives one interrupt line that all of them share. Event pulses (data available, status valid, locality changed, command ready) come in with a target locality. Each pulse records a status bit only if that locality has armed both its master enable and that event's own enable. Software-side accesses arrive as a register offset, a byte lane, an access size and the accessing locality. A separate input names the locality that currently owns the interface.

Reads are not gated and have no side effects. Writes to a locality's enable and status words take effect only for the owning locality. The shared line goes low when a write-to-clear empties the status word of the locality doing the write. It does not look at the other localities, so a pending status bit elsewhere can be left without an asserted line. That is intended behaviour. Choosing the owning locality and generating the events are done elsewhere.

Top module: `lirq_top`

## Requirements
- R1: After reset every locality's enable word reads 0x0000_0008 (low-level polarity, everything else off), every status word reads zero and `irq` is low.
- R2: Offset 0x14 reads the constant 0x0000_0097: bit 4 for low-level support, plus the event mask 0x87. Offset 0x0C reads the parameter `IRQ_NUM` (0 to 15), and writes to 0x0C change nothing.
- R3: Only enable bits 31 (master), 4:3 (polarity), 7, 2, 1 and 0 can be written. Every other enable bit always reads zero, so a full write of 0xFFFF_FFFF reads back 0x8000_009F.
- R4: `acc_size` 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The write data sits in the low bytes of `acc_wdata` and lands at byte lane `acc_addr[1:0]` and upward. Lanes past byte 3 are dropped, and lanes that are not written keep their old contents.
- R5: A write to offset 0x08 or 0x10 is ignored unless `acc_loc` equals `active_loc` and is below 5.
- R6: `ev_pulse` bit 0 maps to status bit 0 (data available), bit 1 to status bit 1 (status valid), bit 2 to status bit 2 (locality changed) and bit 3 to status bit 7 (command ready). An event sets its status bit and raises `irq` on the next edge only if the target locality has enable bit 31 and that event's enable bit both set.
- R7: Events whose `ev_loc` is 5 or higher are ignored.
- R8: Status bits 0, 1, 2 and 7 are write-1-to-clear at offset 0x10. Writing zeros leaves them unchanged.
- R9: `irq` goes low only when a clearing write leaves the writer's status word at zero after it was nonzero. This happens even if another locality still holds status bits. If bits remain in the writer's word, `irq` stays high.
- R10: If an event and a clearing write hit the same status bit in the same cycle, the event wins. The bit stays set and `irq` is high afterwards.
- R11: `rd_data` always shows the word at `acc_addr` for `acc_loc`. Offsets that are not mapped read zero. The per-locality words read zero when `acc_loc` is 5 or higher, while offsets 0x0C and 0x14 still read their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 4 | Event pulses: {command ready, locality changed, status valid, data available} |
| ev_loc | input | 3 | Target locality of the event pulses |
| acc_loc | input | 3 | Locality performing the register access |
| active_loc | input | 3 | Locality that owns the interface (5..7 means none) |
| acc_addr | input | 8 | Byte offset inside the locality window |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_wdata | input | 32 | Write data, low bytes first |
| rd_data | output | 32 | Read data for acc_loc at acc_addr (combinational) |
| irq | output | 1 | Shared interrupt line, high when asserted |

## Verification
The bench targets several corner cases, and each one has a distinct failure mode.

- **Line-drop rule:** one locality's status is emptied while another locality still has a bit pending. A design that checks every locality before dropping would wrongly keep `irq` high.
- **Enables:** events are sent with only the per-event enable set and no master enable, and also with the master enable set and the per-event enable clear. A design that treats the two enables as an OR, or ignores one of them, would record a status bit in these cases.
- **Byte-lane writes:** sub-word and lane-overflowing writes check the merge. A wrong merge would corrupt neighbouring bytes or wrap data into lane 0.
- **Set-versus-clear race:** an event and a clearing write arrive in the same cycle. A design that gives the clear priority would lose the interrupt.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned NEV = 4;

  // word indices (byte offset >> 2) of the registers inside a locality window
  localparam logic [5:0] W_EN  = 6'h02;
  localparam logic [5:0] W_VEC = 6'h03;
  localparam logic [5:0] W_STS = 6'h04;
  localparam logic [5:0] W_CAP = 6'h05;

  localparam logic [31:0] EN_MASTER  = 32'h8000_0000;
  localparam logic [31:0] EN_POL     = 32'h0000_0018;
  localparam logic [31:0] EN_POL_LOW = 32'h0000_0008;
  localparam logic [31:0] EV_SUP     = 32'h0000_0087;
  localparam logic [31:0] EN_WMASK   = EN_MASTER | EN_POL | EV_SUP;
  localparam logic [31:0] CAP_VALUE  = 32'h0000_0010 | EV_SUP;

  // byte enables for a write of the given size starting at the given lane
  function automatic logic [31:0] lane_mask(input logic [1:0] lane, input logic [1:0] size);
    logic [3:0]  be;
    logic [31:0] m;
    case (size)
      2'd0:    be = 4'b0001;
      2'd1:    be = 4'b0011;
      default: be = 4'b1111;
    endcase
    be = be << lane;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] lane_data(input logic [1:0] lane, input logic [31:0] d);
    return d << {lane, 3'b000};
  endfunction

  // event pulse vector to status bit positions
  function automatic logic [31:0] ev_bits(input logic [NEV-1:0] ev);
    return {24'b0, ev[3], 4'b0, ev[2:0]};
  endfunction

endpackage

// File: rtl/lirq_loc_regs.sv
module lirq_loc_regs
  import lirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        sts_wr,
  input  logic [31:0] wr_bits,
  input  logic [31:0] wr_mask,
  input  logic [31:0] ev_in,
  output logic [31:0] en_q,
  output logic [31:0] sts_q,
  output logic        raise,
  output logic        drop
);

  logic [31:0] set_bits, clr_bits, sts_after, sts_d, en_d;

  always_comb begin
    set_bits  = en_q[31] ? (ev_in & en_q & EV_SUP) : 32'h0;
    clr_bits  = sts_wr ? (wr_bits & wr_mask & EV_SUP) : 32'h0;
    sts_after = sts_q & ~clr_bits;
    sts_d     = sts_after | set_bits;
    raise     = |set_bits;
    drop      = (|clr_bits) && (|sts_q) && (sts_after == 32'h0);
    en_d      = en_wr ? ((en_q & ~wr_mask) | (wr_bits & wr_mask & EN_WMASK)) : en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= EN_POL_LOW;
      sts_q <= 32'h0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

endmodule

// File: rtl/lirq_line.sv
module lirq_line #(
  parameter int unsigned NLOC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLOC-1:0] raise_vec,
  input  logic [NLOC-1:0] drop_vec,
  output logic            irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)          irq <= 1'b0;
    else if (|raise_vec) irq <= 1'b1;
    else if (|drop_vec)  irq <= 1'b0;
  end

endmodule

// File: rtl/lirq_rdmux.sv
module lirq_rdmux
  import lirq_pkg::*;
#(
  parameter int unsigned NLOC    = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned IRQ_NUM = 11
) (
  input  logic [NLOC-1:0][31:0] en_all,
  input  logic [NLOC-1:0][31:0] sts_all,
  input  logic [LOC_W-1:0]      acc_loc,
  input  logic [5:0]            word,
  output logic [31:0]           rd_data
);

  logic [31:0] en_sel, sts_sel;

  always_comb begin
    en_sel  = 32'h0;
    sts_sel = 32'h0;
    for (int i = 0; i < NLOC; i++) begin
      if (acc_loc == LOC_W'(i)) begin
        en_sel  = en_all[i];
        sts_sel = sts_all[i];
      end
    end
    case (word)
      W_EN:    rd_data = en_sel;
      W_STS:   rd_data = sts_sel;
      W_VEC:   rd_data = {28'h0, 4'(IRQ_NUM)};
      W_CAP:   rd_data = CAP_VALUE;
      default: rd_data = 32'h0;
    endcase
  end

endmodule

// File: rtl/lirq_top.sv
module lirq_top
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned IRQ_NUM = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ev_pulse,
  input  logic [LOC_W-1:0] ev_loc,
  input  logic [LOC_W-1:0] acc_loc,
  input  logic [LOC_W-1:0] active_loc,
  input  logic [7:0]       acc_addr,
  input  logic [1:0]       acc_size,
  input  logic             acc_wr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      rd_data,
  output logic             irq
);

  logic [5:0]                  word;
  logic                        wr_owned;
  logic                        en_wr_any, sts_wr_any;
  logic [31:0]                 wr_bits, wr_mask, ev_vec;
  logic [NUM_LOC-1:0][31:0]    en_all, sts_all;
  logic [NUM_LOC-1:0]          raise_vec, drop_vec;

  assign word       = acc_addr[7:2];
  assign wr_owned   = acc_wr && (acc_loc < LOC_W'(NUM_LOC)) && (acc_loc == active_loc);
  assign en_wr_any  = wr_owned && (word == W_EN);
  assign sts_wr_any = wr_owned && (word == W_STS);
  assign wr_bits    = lane_data(acc_addr[1:0], acc_wdata);
  assign wr_mask    = lane_mask(acc_addr[1:0], acc_size);
  assign ev_vec     = ev_bits(ev_pulse);

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic mine;
    assign mine = (acc_loc == LOC_W'(g));
    lirq_loc_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (en_wr_any && mine),
      .sts_wr  (sts_wr_any && mine),
      .wr_bits (wr_bits),
      .wr_mask (wr_mask),
      .ev_in   ((ev_loc == LOC_W'(g)) ? ev_vec : 32'h0),
      .en_q    (en_all[g]),
      .sts_q   (sts_all[g]),
      .raise   (raise_vec[g]),
      .drop    (drop_vec[g])
    );
  end

  lirq_line #(.NLOC(NUM_LOC)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_vec (raise_vec),
    .drop_vec  (drop_vec),
    .irq       (irq)
  );

  lirq_rdmux #(.NLOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_NUM(IRQ_NUM)) u_rd (
    .en_all  (en_all),
    .sts_all (sts_all),
    .acc_loc (acc_loc),
    .word    (word),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
  import lirq_pkg::*;
#(
  parameter int unsigned NLOC  = 5,
  parameter int unsigned LOC_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            ev_pulse,
  input logic [LOC_W-1:0]      ev_loc,
  input logic [LOC_W-1:0]      acc_loc,
  input logic [LOC_W-1:0]      active_loc,
  input logic [7:0]            acc_addr,
  input logic                  acc_wr,
  input logic                  irq,
  input logic [NLOC-1:0][31:0] en_all,
  input logic [NLOC-1:0][31:0] sts_all
);

  logic [31:0] tgt_en;
  logic        hit, stray_bits;

  always_comb begin
    tgt_en     = 32'h0;
    stray_bits = 1'b0;
    for (int i = 0; i < NLOC; i++) begin
      if (ev_loc == LOC_W'(i)) tgt_en = en_all[i];
      if ((en_all[i] & ~EN_WMASK) != 32'h0) stray_bits = 1'b1;
    end
    hit = tgt_en[31] && ((ev_bits(ev_pulse) & tgt_en & EV_SUP) != 32'h0);
  end

  // R6
  raise_line_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> irq);

  // R5
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_loc != active_loc && ev_pulse == 4'h0) |=> ($stable(en_all) && $stable(sts_all)));

  // R9
  fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(acc_wr && acc_loc == active_loc && acc_addr[7:2] == W_STS));

  // R3
  en_bits_chk: assert property (@(posedge clk) disable iff (!rst_n) !stray_bits);

  // R7
  stray_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_loc >= LOC_W'(NLOC) && !acc_wr) |=> $stable(sts_all));

endmodule

bind lirq_top lirq_chk #(.NLOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_pulse   (ev_pulse),
  .ev_loc     (ev_loc),
  .acc_loc    (acc_loc),
  .active_loc (active_loc),
  .acc_addr   (acc_addr),
  .acc_wr     (acc_wr),
  .irq        (irq),
  .en_all     (en_all),
  .sts_all    (sts_all)
);

// File: tb/tb_lirq_top.sv
module tb_lirq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev_pulse = 4'h0;
  logic [2:0]  ev_loc = 3'd0;
  logic [2:0]  acc_loc = 3'd0;
  logic [2:0]  active_loc = 3'd7;
  logic [7:0]  acc_addr = 8'h0;
  logic [1:0]  acc_size = 2'd2;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lirq_top #(.NUM_LOC(5), .LOC_W(3), .IRQ_NUM(11)) dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ev_loc(ev_loc),
    .acc_loc(acc_loc), .active_loc(active_loc), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus: optional write plus optional event
  task automatic step(input logic wr, input logic [2:0] loc, input logic [2:0] act,
                      input logic [7:0] addr, input logic [1:0] size, input logic [31:0] data,
                      input logic [3:0] evp, input logic [2:0] evl);
    @(negedge clk);
    acc_wr = wr; acc_loc = loc; active_loc = act; acc_addr = addr;
    acc_size = size; acc_wdata = data; ev_pulse = evp; ev_loc = evl;
    @(negedge clk);
    acc_wr = 1'b0; ev_pulse = 4'h0;
  endtask

  task automatic wr(input logic [2:0] loc, input logic [2:0] act, input logic [7:0] addr,
                    input logic [1:0] size, input logic [31:0] data);
    step(1'b1, loc, act, addr, size, data, 4'h0, 3'd0);
  endtask

  task automatic ev(input logic [2:0] loc, input logic [3:0] bits);
    step(1'b0, 3'd0, active_loc, 8'h0, 2'd2, 32'h0, bits, loc);
  endtask

  task automatic rd(input string tag, input logic [2:0] loc, input logic [7:0] addr,
                    input logic [31:0] exp);
    @(negedge clk);
    acc_loc = loc; acc_addr = addr; acc_wr = 1'b0;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic t_reset;
    rd("R1 enable loc0", 3'd0, 8'h08, 32'h8);
    rd("R1 enable loc4", 3'd4, 8'h08, 32'h8);
    rd("R1 status loc0", 3'd0, 8'h10, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_consts;
    rd("R2 capability", 3'd0, 8'h14, 32'h97);
    rd("R2 vector", 3'd0, 8'h0C, 32'd11);
    wr(3'd0, 3'd0, 8'h0C, 2'd2, 32'h3);
    rd("R2 vector after write", 3'd0, 8'h0C, 32'd11);
    rd("R11 unmapped offset", 3'd0, 8'h00, 32'h0);
  endtask

  task automatic t_enmask;
    wr(3'd0, 3'd0, 8'h08, 2'd2, 32'hFFFF_FFFF);
    rd("R3 writable bits", 3'd0, 8'h08, 32'h8000_009F);
    wr(3'd0, 3'd0, 8'h08, 2'd2, 32'h0);
    rd("R3 clear all", 3'd0, 8'h08, 32'h0);
  endtask

  task automatic t_lanes;
    wr(3'd0, 3'd0, 8'h0B, 2'd0, 32'h80);
    rd("R4 byte lane3", 3'd0, 8'h08, 32'h8000_0000);
    wr(3'd0, 3'd0, 8'h08, 2'd0, 32'h05);
    rd("R4 byte lane0 keeps lane3", 3'd0, 8'h08, 32'h8000_0005);
    wr(3'd0, 3'd0, 8'h0A, 2'd1, 32'h0);
    rd("R4 halfword upper", 3'd0, 8'h08, 32'h0000_0005);
    wr(3'd0, 3'd0, 8'h0B, 2'd2, 32'hFFFF_FFFF);
    rd("R4 overflow lanes dropped", 3'd0, 8'h08, 32'h8000_0005);
  endtask

  task automatic t_gate;
    wr(3'd0, 3'd1, 8'h08, 2'd2, 32'h0);
    rd("R5 enable write by non-owner", 3'd0, 8'h08, 32'h8000_0005);
  endtask

  task automatic t_master_off;
    wr(3'd2, 3'd2, 8'h08, 2'd2, 32'h87);
    rd("R3 loc2 enable", 3'd2, 8'h08, 32'h87);
    ev(3'd2, 4'hF);
    rd("R6 no master enable status", 3'd2, 8'h10, 32'h0);
    check("R6 no master enable irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_events;
    ev(3'd0, 4'b0010);
    rd("R6 event not enabled", 3'd0, 8'h10, 32'h0);
    check("R6 event not enabled irq", {31'h0, irq}, 32'h0);
    ev(3'd0, 4'b0001);
    rd("R6 data-avail set", 3'd0, 8'h10, 32'h1);
    check("R6 irq raised", {31'h0, irq}, 32'h1);
    ev(3'd0, 4'b0100);
    rd("R6 loc-changed set", 3'd0, 8'h10, 32'h5);
  endtask

  task automatic t_w1c;
    wr(3'd0, 3'd0, 8'h10, 2'd2, 32'h0);
    rd("R8 zero write keeps", 3'd0, 8'h10, 32'h5);
    wr(3'd0, 3'd0, 8'h10, 2'd2, 32'h4);
    rd("R8 partial clear", 3'd0, 8'h10, 32'h1);
    check("R9 irq stays while bits remain", {31'h0, irq}, 32'h1);
    wr(3'd0, 3'd0, 8'h10, 2'd2, 32'h1);
    rd("R8 full clear", 3'd0, 8'h10, 32'h0);
    check("R9 irq dropped", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_shared_drop;
    wr(3'd0, 3'd0, 8'h08, 2'd2, 32'h8000_0081);
    wr(3'd1, 3'd1, 8'h08, 2'd2, 32'h8000_0001);
    ev(3'd0, 4'b1001);
    ev(3'd1, 4'b0001);
    rd("R6 cmd-ready and data-avail", 3'd0, 8'h10, 32'h81);
    check("R6 irq shared", {31'h0, irq}, 32'h1);
    wr(3'd0, 3'd0, 8'h10, 2'd0, 32'h81);
    rd("R8 byte clear", 3'd0, 8'h10, 32'h0);
    check("R9 drops despite loc1 pending", {31'h0, irq}, 32'h0);
    rd("R9 loc1 still pending", 3'd1, 8'h10, 32'h1);
    wr(3'd1, 3'd0, 8'h10, 2'd2, 32'h1);
    rd("R5 status clear by non-owner", 3'd1, 8'h10, 32'h1);
  endtask

  task automatic t_stray;
    ev(3'd5, 4'hF);
    check("R7 stray event irq", {31'h0, irq}, 32'h0);
    rd("R7 loc0 untouched", 3'd0, 8'h10, 32'h0);
    rd("R11 out-of-range loc status", 3'd5, 8'h10, 32'h0);
    rd("R11 out-of-range loc capability", 3'd5, 8'h14, 32'h97);
  endtask

  task automatic t_race;
    step(1'b1, 3'd1, 3'd1, 8'h10, 2'd2, 32'h1, 4'b0001, 3'd1);
    rd("R10 event wins bit", 3'd1, 8'h10, 32'h1);
    check("R10 event wins irq", {31'h0, irq}, 32'h1);
    wr(3'd1, 3'd1, 8'h10, 2'd2, 32'h1);
    check("R9 clear after race", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_consts();
    t_enmask();
    t_lanes();
    t_gate();
    t_master_off();
    t_events();
    t_w1c();
    t_shared_drop();
    t_stray();
    t_race();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule